// File: doc/BRIEF.md
# I2C Byte-Buffered Master Controller

This block is an I2C bus master controlled through a small register port. Software uses a single one-byte data buffer for every transfer. It writes the buffer and then sets a transfer-byte bit in the control register, and the controller moves exactly that one byte over the bus. The byte may be an address byte (7-bit target address with the read/not-write flag in bit 0) or a data byte. If the transfer-byte bit is set while the bus is free, the controller first issues a START and treats the byte as an address. If the start bit is set together with it while the bus is held, the controller issues a repeated START.

After every byte the controller holds SCL low and waits for software. This wait state lasts until software either hands over the next byte or asks for a STOP. In transmit mode, a tx-empty flag is raised once the acknowledge clock has completed. In receive mode, the received byte moves into the buffer only after the acknowledge clock, and a rx-full flag is raised. The next byte cannot start until software has read the buffer. The acknowledge value to send is chosen for each byte in the same control write that sets the transfer-byte bit. SCL runs at 100 kbit/s or 400 kbit/s, and each half period is counted from the system clock.

Register map used throughout:
- Address 0 is DATA.
- Address 1 is CTRL:
  - bit0 transfer-byte
  - bit1 start
  - bit2 stop
  - bit3 send-NAK
  - bit4 fast
  - bit5 tx-empty interrupt enable
  - bit6 rx-full interrupt enable
- Address 2 is STATUS:
  - bit0 tx-empty
  - bit1 rx-full
  - bit2 address-NAK
  - bit3 busy
  - bit4 receive mode

The bus lines are open-drain. An output of 1 pulls the line low.

Top module: `i2c_bytebuf_master`

## Requirements
- R1: After reset both line drivers are released, `irq` is low and STATUS (address 2) reads 0.
- R2: Writing DATA (address 0) alone starts nothing. A START and a byte go out only when CTRL bit0 (transfer-byte) is set. The byte is shifted MSB first, and the first byte after a START is the buffer contents as the address byte.
- R3: The controller forms START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high). At all other times SDA changes only while SCL is low.
- R4: With CTRL bit4 clear, each SCL high phase lasts CLK_HZ/(2*100000) system clocks. With CTRL bit4 set, it lasts CLK_HZ/(2*400000) system clocks.
- R5: STATUS bit0 (tx-empty) is set after a transmitted byte only once its ninth (acknowledge) clock has finished. Writing DATA clears it. `irq` goes high while it is set and CTRL bit5 is set.
- R6: When a byte ends without a stop request, SCL is held low with no further clocks until software acts. CTRL bit0 (and bits 1, 2) read back 0 once the controller has accepted the request.
- R7: A NAK on the address byte sets STATUS bit2. Writing 1 to STATUS bit2 clears it.
- R8: In receive mode, the received byte is copied into DATA after its acknowledge clock and STATUS bit1 (rx-full) is set. Reading DATA clears bit1. `irq` goes high while bit1 and CTRL bit6 are set.
- R9: While STATUS bit1 is set, a pending transfer-byte request is not accepted. CTRL bit0 stays 1 and SCL stays held low until DATA is read.
- R10: In receive mode, the acknowledge bit driven after a byte is ACK (SDA low) when CTRL bit3 was 0 in the request and NAK (SDA released) when it was 1.
- R11: Setting CTRL bit1 with bit0 while the bus is held produces a repeated START with no STOP, followed by a new address byte.
- R12: A request with CTRL bit2 set, given with bit0 or alone while the bus is held, ends with a STOP. Both lines are then released and STATUS bit3 (busy) returns to 0.
- R13: STATUS bit3 is 1 while a transaction is open. STATUS bit4 is 1 after an address byte with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 DATA, 1 CTRL, 2 STATUS) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request (tx-empty or rx-full, each maskable) |
| scl_low_o | output | 1 | 1 pulls SCL low |
| sda_low_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
The bench attaches a behavioural target device to the wired bus and sweeps a set of data bytes at both rates. It checks every byte that arrives and measures the SCL high time. A design that raised tx-empty before the acknowledge clock would show fewer than nine SCL rises at the flag. A design that kept clocking during the wait state, or that accepted a request over an unread receive buffer, would show extra SCL rises during a long idle window. Per-byte ACK/NAK is checked from the target's side, so an inverted or stale acknowledge bit shows up in its log. The repeated-START path and the STOP-only request are checked by counting START and STOP conditions, so a design that slipped in a STOP or missed one changes those counts.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_HOLD,
    ST_RS_LO,
    ST_RS_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_BUS_FREE
  } eng_state_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // control field positions
  localparam int C_XFER  = 0;
  localparam int C_START = 1;
  localparam int C_STOP  = 2;
  localparam int C_NAK   = 3;
  localparam int C_FAST  = 4;
  localparam int C_TXIE  = 5;
  localparam int C_RXIE  = 6;

  // status field positions
  localparam int S_TXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_ANAK = 2;
  localparam int S_BUSY = 3;
  localparam int S_RXM  = 4;

endpackage

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STD_HZ  = 100_000,
  parameter int FAST_HZ = 400_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int HALF_STD  = CLK_HZ / (2 * STD_HZ);
  localparam int HALF_FAST = CLK_HZ / (2 * FAST_HZ);
  localparam int CW        = $clog2(HALF_STD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(HALF_FAST - 1) : CW'(HALF_STD - 1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt >= lim) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HALF_STD - 1));

endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  // engine side
  input  logic              accept,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              nak_seen,
  input  logic              busy,
  input  logic              rx_mode,
  output logic [BYTE_W-1:0] buf_q,
  output logic              xfer_q,
  output logic              start_q,
  output logic              stop_q,
  output logic              nak_q,
  output logic              fast_q,
  output logic              rx_full
);
  logic txe_ie, rxf_ie, tx_empty, addr_nak;
  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_DATA: rd_mux = buf_q;
      A_CTRL: begin
        rd_mux[C_XFER]  = xfer_q;
        rd_mux[C_START] = start_q;
        rd_mux[C_STOP]  = stop_q;
        rd_mux[C_NAK]   = nak_q;
        rd_mux[C_FAST]  = fast_q;
        rd_mux[C_TXIE]  = txe_ie;
        rd_mux[C_RXIE]  = rxf_ie;
      end
      A_STAT: begin
        rd_mux[S_TXE]  = tx_empty;
        rd_mux[S_RXF]  = rx_full;
        rd_mux[S_ANAK] = addr_nak;
        rd_mux[S_BUSY] = busy;
        rd_mux[S_RXM]  = rx_mode;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q     <= '0;
      xfer_q    <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      nak_q     <= 1'b0;
      fast_q    <= 1'b0;
      txe_ie    <= 1'b0;
      rxf_ie    <= 1'b0;
      tx_empty  <= 1'b0;
      rx_full   <= 1'b0;
      addr_nak  <= 1'b0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (accept) begin
        xfer_q  <= 1'b0;
        start_q <= 1'b0;
        stop_q  <= 1'b0;
      end
      if (bus_wr) begin
        unique case (bus_addr)
          A_DATA: begin
            buf_q    <= bus_wdata;
            tx_empty <= 1'b0;
          end
          A_CTRL: begin
            xfer_q  <= bus_wdata[C_XFER];
            start_q <= bus_wdata[C_START];
            stop_q  <= bus_wdata[C_STOP];
            nak_q   <= bus_wdata[C_NAK];
            fast_q  <= bus_wdata[C_FAST];
            txe_ie  <= bus_wdata[C_TXIE];
            rxf_ie  <= bus_wdata[C_RXIE];
          end
          A_STAT: begin
            if (bus_wdata[S_TXE])  tx_empty <= 1'b0;
            if (bus_wdata[S_ANAK]) addr_nak <= 1'b0;
          end
          default: ;
        endcase
      end
      if (bus_rd && bus_addr == A_DATA) rx_full <= 1'b0;
      if (tx_done)  tx_empty <= 1'b1;
      if (rx_done) begin
        buf_q   <= rx_byte;
        rx_full <= 1'b1;
      end
      if (nak_seen) addr_nak <= 1'b1;
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= (tx_empty && txe_ie) || (rx_full && rxf_ie);
    end
  end

  // R6
  xfer_clear_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !(bus_wr && bus_addr == A_CTRL) |=> !xfer_q);

  // R8
  rx_full_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_full);

  // R5
  tx_empty_set_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> tx_empty);

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              xfer,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              nak_send,
  input  logic [BYTE_W-1:0] buf_q,
  input  logic              rx_full,
  input  logic              sda_in,
  output logic              run,
  output logic              accept,
  output logic              tx_done,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              nak_seen,
  output logic              busy,
  output logic              rx_mode,
  output logic              scl_low,
  output logic              sda_low
);
  localparam int BCW = $clog2(BYTE_W);

  eng_state_e        state;
  logic [BYTE_W-1:0] shift;
  logic [BCW-1:0]    bitcnt;
  logic              addr_ph, stop_cap, nak_cap;
  logic              go, drive_tx;

  assign go       = xfer && !rx_full;
  assign drive_tx = addr_ph || !rx_mode;
  assign run      = (state != ST_IDLE) && (state != ST_HOLD);
  assign busy     = (state != ST_IDLE);
  assign rx_byte  = shift;
  assign accept   = ((state == ST_IDLE) && go) ||
                    ((state == ST_HOLD) && (go || (stop_req && !xfer)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shift    <= '0;
      bitcnt   <= '0;
      addr_ph  <= 1'b0;
      stop_cap <= 1'b0;
      nak_cap  <= 1'b0;
      rx_mode  <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
      nak_seen <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
      nak_seen <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            shift    <= buf_q;
            addr_ph  <= 1'b1;
            rx_mode  <= buf_q[0];
            stop_cap <= stop_req;
            nak_cap  <= nak_send;
            sda_low  <= 1'b1;
            state    <= ST_START;
          end
        end
        ST_HOLD: begin
          if (go) begin
            shift    <= buf_q;
            bitcnt   <= '0;
            stop_cap <= stop_req;
            nak_cap  <= nak_send;
            if (start_req) begin
              addr_ph <= 1'b1;
              rx_mode <= buf_q[0];
              sda_low <= 1'b0;
              state   <= ST_RS_LO;
            end else begin
              sda_low <= rx_mode ? 1'b0 : ~buf_q[BYTE_W-1];
              state   <= ST_BIT_LO;
            end
          end else if (stop_req && !xfer) begin
            sda_low <= 1'b1;
            state   <= ST_STOP_LO;
          end
        end
        ST_RS_LO: if (tick) begin
          scl_low <= 1'b0;
          state   <= ST_RS_HI;
        end
        ST_RS_HI: if (tick) begin
          sda_low <= 1'b1;
          state   <= ST_START;
        end
        ST_START: if (tick) begin
          scl_low <= 1'b1;
          sda_low <= ~shift[BYTE_W-1];
          bitcnt  <= '0;
          state   <= ST_BIT_LO;
        end
        ST_BIT_LO: if (tick) begin
          scl_low <= 1'b0;
          state   <= ST_BIT_HI;
        end
        ST_BIT_HI: if (tick) begin
          shift   <= {shift[BYTE_W-2:0], sda_in};
          scl_low <= 1'b1;
          if (bitcnt == BCW'(BYTE_W - 1)) begin
            sda_low <= drive_tx ? 1'b0 : ~nak_cap;
            state   <= ST_ACK_LO;
          end else begin
            bitcnt  <= bitcnt + 1'b1;
            sda_low <= drive_tx ? ~shift[BYTE_W-2] : 1'b0;
            state   <= ST_BIT_LO;
          end
        end
        ST_ACK_LO: if (tick) begin
          scl_low <= 1'b0;
          state   <= ST_ACK_HI;
        end
        ST_ACK_HI: if (tick) begin
          scl_low <= 1'b1;
          if (drive_tx) begin
            tx_done  <= 1'b1;
            nak_seen <= addr_ph && sda_in;
          end else begin
            rx_done <= 1'b1;
          end
          addr_ph <= 1'b0;
          if (stop_cap) begin
            sda_low <= 1'b1;
            state   <= ST_STOP_LO;
          end else begin
            sda_low <= 1'b0;
            state   <= ST_HOLD;
          end
        end
        ST_STOP_LO: if (tick) begin
          scl_low <= 1'b0;
          state   <= ST_STOP_HI;
        end
        ST_STOP_HI: if (tick) begin
          sda_low <= 1'b0;
          state   <= ST_BUS_FREE;
        end
        ST_BUS_FREE: if (tick) begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_HOLD |-> scl_low);

  // R3
  sda_high_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BIT_HI || state == ST_ACK_HI) && !scl_low && !$past(scl_low)
      |-> $stable(sda_low));

  // R5
  tx_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $past(state) == ST_ACK_HI && scl_low);

  // R8
  rx_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(state) == ST_ACK_HI && !tx_done);

  // R12
  bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_BUS_FREE |-> !scl_low && !sda_low);

endmodule

// File: rtl/i2c_bytebuf_master.sv
module i2c_bytebuf_master
  import i2c_bm_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STD_HZ  = 100_000,
  parameter int FAST_HZ = 400_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_low_o,
  output logic       sda_low_o,
  input  logic       sda_i
);
  logic              tick, run, accept, tx_done, rx_done, nak_seen;
  logic              busy, rx_mode, rx_full;
  logic              xfer_q, start_q, stop_q, nak_q, fast_q;
  logic [BYTE_W-1:0] rx_byte, buf_q;

  i2c_rate_gen #(
    .CLK_HZ (CLK_HZ),
    .STD_HZ (STD_HZ),
    .FAST_HZ(FAST_HZ)
  ) u_rate (
    .clk (clk),
    .rst (rst),
    .run (run),
    .fast(fast_q),
    .tick(tick)
  );

  i2c_bm_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (reg_wr),
    .bus_rd   (reg_rd),
    .bus_addr (reg_addr),
    .bus_wdata(reg_wdata),
    .bus_rdata(reg_rdata),
    .irq      (irq),
    .accept   (accept),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte),
    .nak_seen (nak_seen),
    .busy     (busy),
    .rx_mode  (rx_mode),
    .buf_q    (buf_q),
    .xfer_q   (xfer_q),
    .start_q  (start_q),
    .stop_q   (stop_q),
    .nak_q    (nak_q),
    .fast_q   (fast_q),
    .rx_full  (rx_full)
  );

  i2c_byte_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .xfer     (xfer_q),
    .start_req(start_q),
    .stop_req (stop_q),
    .nak_send (nak_q),
    .buf_q    (buf_q),
    .rx_full  (rx_full),
    .sda_in   (sda_i),
    .run      (run),
    .accept   (accept),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte),
    .nak_seen (nak_seen),
    .busy     (busy),
    .rx_mode  (rx_mode),
    .scl_low  (scl_low_o),
    .sda_low  (sda_low_o)
  );

  // R9
  no_accept_over_rx_chk: assert property (@(posedge clk) disable iff (rst)
    accept && xfer_q |-> !rx_full);

endmodule

// File: tb/tb_i2c_bytebuf_master.sv
`timescale 1ns/1ps
module tb_i2c_bytebuf_master;
  localparam int CLK_HZ = 4_000_000;
  localparam int HS = CLK_HZ / (2 * 100_000);
  localparam int HF = CLK_HZ / (2 * 400_000);
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0;
  logic rst;
  logic reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq, scl_low_o, sda_low_o, sda_i;
  logic sl_low;
  logic scl_line, sda_line;

  always #10 clk = ~clk;

  assign scl_line = ~scl_low_o;
  assign sda_line = ~sda_low_o & ~sl_low;
  assign sda_i    = sda_line;

  i2c_bytebuf_master #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .sda_i(sda_i)
  );

  int tests = 0, fails = 0;

  function automatic logic [7:0] rd_pat(int i);
    return 8'h96 ^ 8'(i * 59);
  endfunction

  // behavioural target device, evaluated away from the active edge
  logic p_scl = 1'b1, p_sda = 1'b1;
  int starts = 0, stops = 0, rises = 0, bitc = 0, tx_idx = 0, nm = 0;
  int hcnt = 0, last_high = 0;
  logic in_ack = 0, addr_ph = 0, s_tx = 0, s_sel = 0;
  logic [7:0] sh = 0, txb = 0, last_byte = 0;
  logic mack_log [0:15];

  always @(negedge clk) begin
    if (rst) begin
      sl_low = 1'b0;
    end else begin
      if (scl_line) hcnt++;
      if (scl_line && p_scl && p_sda && !sda_line) begin
        starts++; bitc = 0; in_ack = 0; addr_ph = 1; s_tx = 0; sl_low = 0; rises = 0;
      end else if (scl_line && p_scl && !p_sda && sda_line) begin
        stops++; s_sel = 0; s_tx = 0; sl_low = 0;
      end else if (scl_line && !p_scl) begin
        rises++;
        if (!in_ack) begin sh = {sh[6:0], sda_line}; bitc++; end
        else if (s_tx) begin mack_log[nm] = sda_line; nm++; end
      end else if (!scl_line && p_scl) begin
        last_high = hcnt;
        if (!in_ack && bitc == 8) begin
          in_ack = 1;
          if (addr_ph) begin
            last_byte = sh; s_sel = (sh[7:1] == SLV); sl_low = s_sel;
          end else if (!s_tx) begin
            last_byte = sh; sl_low = s_sel;
          end else sl_low = 0;
        end else if (in_ack) begin
          in_ack = 0; bitc = 0;
          if (addr_ph) begin addr_ph = 0; s_tx = s_sel & sh[0]; end
          else if (s_tx && mack_log[nm-1]) s_tx = 0;
          sl_low = 0;
          if (s_tx) begin txb = rd_pat(tx_idx); tx_idx++; sl_low = ~txb[7]; end
        end else if (s_tx && bitc >= 1 && bitc <= 7) begin
          sl_low = ~txb[7-bitc];
        end
      end
      if (!scl_line) hcnt = 0;
      p_scl = scl_line; p_sda = sda_line;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdreg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_stat(int b, logic e, string req);
    logic [7:0] s;
    s = 0;
    for (int i = 0; i < 5000; i++) begin
      rdreg(2'd2, s);
      if (s[b] == e) break;
    end
    chk(req, s[b], e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, d;
    int r0, s0, p0;
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 scl", scl_low_o, 0);
    chk("R1 sda", sda_low_o, 0);
    chk("R1 irq", irq, 0);
    rdreg(2'd2, v); chk("R1 status", v, 0);

    // R2: buffer write alone starts nothing
    wrreg(2'd0, 8'hA0);
    repeat (100) @(negedge clk);
    chk("R2 no start", starts, 0);
    chk("R2 idle scl", scl_low_o, 0);
    wrreg(2'd1, 8'h23);
    rdreg(2'd2, v); chk("R13 busy", v[3], 1);
    wait_stat(0, 1, "R5 txe");
    chk("R5 nine clocks", rises, 9);
    chk("R2 addr byte", last_byte, 8'hA0);
    chk("R3 start", starts, 1);
    chk("R5 irq", irq, 1);
    rdreg(2'd1, v); chk("R6 self-clear", v[0], 0);
    chk("R4 std high", last_high, HS);

    // R6: wait state
    r0 = rises;
    repeat (300) @(negedge clk);
    chk("R6 no clocks", rises, r0);
    chk("R6 scl held", scl_low_o, 1);

    // sweep of data bytes at both rates
    for (int k = 0; k < 12; k++) begin
      d = 8'(k * 8'h35) ^ 8'h5A;
      wrreg(2'd0, d);
      rdreg(2'd2, v); chk("R5 cleared", v[0], 0);
      wrreg(2'd1, {3'b000, k[0], 4'b0001});
      wait_stat(0, 1, "R5 txe sweep");
      chk("R2 data byte", last_byte, d);
      chk("R4 high time", last_high, k[0] ? HF : HS);
    end

    // R12: stop-only request
    wrreg(2'd1, 8'h04);
    wait_stat(3, 0, "R12 busy clear");
    chk("R12 stop", stops, 1);
    chk("R12 scl", scl_low_o, 0);
    chk("R12 sda", sda_low_o, 0);
    chk("R3 single start", starts, 1);

    // R7: address NAK
    wrreg(2'd0, 8'h44);
    wrreg(2'd1, 8'h07);
    wait_stat(3, 0, "R12 busy after nak");
    rdreg(2'd2, v); chk("R7 nak flag", v[2], 1);
    chk("R3 stop after nak", stops, 2);
    wrreg(2'd2, 8'h04);
    rdreg(2'd2, v); chk("R7 nak clear", v[2], 0);

    // receive
    wrreg(2'd0, 8'hA1);
    wrreg(2'd1, 8'h03);
    wait_stat(0, 1, "R5 txe addr rd");
    rdreg(2'd2, v); chk("R13 rx mode", v[4], 1);
    wrreg(2'd1, 8'h41);
    wait_stat(1, 1, "R8 rxf");
    chk("R8 irq", irq, 1);
    rdreg(2'd0, v); chk("R8 byte0", v, rd_pat(0));
    rdreg(2'd2, v); chk("R8 rxf clear", v[1], 0);
    wrreg(2'd1, 8'h41);
    wait_stat(1, 1, "R8 rxf 2");
    r0 = rises;
    wrreg(2'd1, 8'h4D);
    repeat (300) @(negedge clk);
    rdreg(2'd1, v); chk("R9 xfer pending", v[0], 1);
    chk("R9 no clocks", rises, r0);
    rdreg(2'd0, v); chk("R8 byte1", v, rd_pat(1));
    wait_stat(3, 0, "R12 busy rd");
    rdreg(2'd0, v); chk("R8 byte2", v, rd_pat(2));
    chk("R10 ack0", mack_log[0], 0);
    chk("R10 ack1", mack_log[1], 0);
    chk("R10 nak2", mack_log[2], 1);
    chk("R12 stop rd", stops, 3);

    // R11: repeated start, write then read
    s0 = starts; p0 = stops;
    wrreg(2'd0, 8'hA0);
    wrreg(2'd1, 8'h03);
    wait_stat(0, 1, "R5 txe rs");
    wrreg(2'd0, 8'h11);
    wrreg(2'd1, 8'h01);
    wait_stat(0, 1, "R5 txe rs data");
    chk("R2 rs data", last_byte, 8'h11);
    wrreg(2'd0, 8'hA1);
    wrreg(2'd1, 8'h03);
    wait_stat(0, 1, "R5 txe rs addr");
    chk("R11 starts", starts, s0 + 2);
    chk("R11 no stop", stops, p0);
    chk("R11 addr", last_byte, 8'hA1);
    wrreg(2'd1, 8'h4D);
    wait_stat(3, 0, "R12 busy rs");
    rdreg(2'd0, v); chk("R8 byte3", v, rd_pat(3));
    chk("R10 nak3", mack_log[3], 1);
    chk("R12 stop rs", stops, p0 + 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule